// File: doc/BRIEF.md
# Edge-Qualified Event Counter with Snapshot Register

This block counts events and keeps a readable snapshot of the count. An event is either an edge on an asynchronous external pin or a rising edge on an internal synchronous logic output. A select input chooses the source. For the pin, a polarity input chooses the rising or the falling edge. Each accepted event moves the counter up or down by one, depending on a direction input. The counter wraps at either end, and each wrap sets a sticky flag.

The counter has to be loaded before it counts, and the same load also clears the wrap flag and the spacing guard. An event is accepted only if it comes at least one timer period plus two clock cycles after the last accepted event. The timer period is a parameter given in clock cycles. An event that arrives too early is dropped, not held for later.

A snapshot register follows the count one cycle behind it. To read it, software raises a freeze request and waits for the acknowledge. While the request stays high the snapshot holds still, and the counter keeps counting. When the request drops, the snapshot picks up the live count on the next clock.

Top module: `evcap_counter`

## Requirements
- R1: With `src_sel`=0 the pin is the source. With `pin_fall_sel`=0 only rising pin edges count, and with `pin_fall_sel`=1 only falling edges count. The other edge leaves the count unchanged.
- R2: With `src_sel`=1 only rising edges of `cell_in` count, and a level held high counts once. Edges on the source that is not selected never change the count.
- R3: Each accepted event adds one when `count_down`=0 and subtracts one when `count_down`=1. With no accepted event and no load, the count holds.
- R4: The count wraps from 2^WIDTH-1 to 0 going up and from 0 to 2^WIDTH-1 going down. Each wrap sets `wrap_flag`, which stays set until the next load. Reset clears it.
- R5: A `load_en` cycle writes `load_val` into the counter and clears `wrap_flag`. After reset, no event is counted until the first load.
- R6: When no freeze is requested, `image_q` equals the count one clock later. After a `cell_in` event edge, `image_q` still shows the old value for one cycle and then shows the new value.
- R7: `freeze_ack` is `freeze_req` delayed by one clock. While `freeze_req` is high, `image_q` holds still and events continue to be counted.
- R8: On the first clock after `freeze_req` falls, `image_q` takes the current count.
- R9: An event is accepted only if at least TICK_DIV+2 clocks have passed since the last accepted event (6 with the defaults). Earlier events are dropped. A load clears this spacing window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 1 | Asynchronous external event pin |
| cell_in | input | 1 | Synchronous internal event source |
| src_sel | input | 1 | Event source: 0 pin, 1 internal |
| pin_fall_sel | input | 1 | Pin edge that counts: 0 rising, 1 falling |
| count_down | input | 1 | Count direction: 0 up, 1 down |
| load_en | input | 1 | Load the counter from `load_val` |
| load_val | input | WIDTH | Initial count |
| freeze_req | input | 1 | Request to hold the snapshot |
| freeze_ack | output | 1 | Snapshot is held |
| image_q | output | WIDTH | Snapshot of the count |
| wrap_flag | output | 1 | Sticky wrap indicator |

## Verification
On every cycle, the assertions check the one-step count movement and the hold when nothing happens. They also check the freeze of the snapshot, the one-cycle acknowledge delay, the snapshot tracking and reload, the stickiness of the wrap flag, the lockout before the first load, and the minimum spacing between accepted events. Some behaviour shows only in the bench scenarios: which pin edge is selected by polarity, that the source not selected is ignored, the exact wrap values, and that early events are dropped and not deferred. The bench shows these by comparing the snapshot with a model count over directed sequences and a long seeded random pulse train.

// File: rtl/evcap_pkg.sv
package evcap_pkg;

   typedef enum logic {
      SRC_PIN  = 1'b0,
      SRC_CELL = 1'b1
   } evsrc_e;

   // minimum distance, in clocks, between two accepted events
   function automatic int spacing_gap(input int tick_div);
      return tick_div + 2;
   endfunction

endpackage

// File: rtl/evcap_edge_sel.sv
module evcap_edge_sel #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_in,
   input  logic cell_in,
   input  logic src_sel,
   input  logic pin_fall_sel,
   output logic ev_raw
);
   import evcap_pkg::*;

   logic pin_s;
   logic pin_prev;
   logic cell_prev;
   logic pin_ev;
   logic cell_ev;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign pin_s = pin_in;
      end else begin : g_sync
         logic [SYNC_STAGES:0] chain;
         assign chain[0] = pin_in;
         for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[g+1] <= 1'b0;
               else        chain[g+1] <= chain[g];
            end
         end
         assign pin_s = chain[SYNC_STAGES];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_prev  <= 1'b0;
         cell_prev <= 1'b0;
      end else begin
         pin_prev  <= pin_s;
         cell_prev <= cell_in;
      end
   end

   always_comb begin
      if (pin_fall_sel) pin_ev = !pin_s && pin_prev;
      else              pin_ev = pin_s && !pin_prev;
      cell_ev = cell_in && !cell_prev;
      ev_raw  = (evsrc_e'(src_sel) == SRC_CELL) ? cell_ev : pin_ev;
   end

   // a held level never yields two events in a row (R2)
   assert_cell_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_raw && src_sel) |=> !(ev_raw && src_sel));
   // a pin edge with unchanged polarity cannot repeat next cycle (R1)
   assert_pin_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_raw && !src_sel) |=> !(ev_raw && !src_sel && $stable(pin_fall_sel)));

endmodule

// File: rtl/evcap_spacer.sv
module evcap_spacer #(
   parameter int GAP = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ev_raw,
   input  logic enable,
   input  logic clear,
   output logic accept
);
   localparam int GW = (GAP > 2) ? $clog2(GAP) : 2;
   localparam int SW = $clog2(GAP + 1) + 1;

   logic [GW-1:0] guard_q;

   assign accept = ev_raw && enable && (guard_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               guard_q <= '0;
      else if (clear)           guard_q <= '0;
      else if (accept)          guard_q <= GW'(GAP - 1);
      else if (guard_q != '0)   guard_q <= guard_q - 1'b1;
   end

   // checker state: clocks since the previous accepted event
   logic [SW-1:0] since_q;
   logic          seen_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since_q <= '0;
         seen_q  <= 1'b0;
      end else if (clear) begin
         since_q <= '0;
         seen_q  <= 1'b0;
      end else if (accept) begin
         since_q <= SW'(1);
         seen_q  <= 1'b1;
      end else if (since_q < SW'(GAP)) begin
         since_q <= since_q + 1'b1;
      end
   end

   assert_min_spacing_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && seen_q) |-> (since_q >= SW'(GAP)));
   assert_no_back_to_back_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !clear) |=> !accept);

endmodule

// File: rtl/evcap_core.sv
module evcap_core #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             accept,
   input  logic             count_down,
   input  logic             load_en,
   input  logic [WIDTH-1:0] load_val,
   output logic [WIDTH-1:0] count_q,
   output logic             wrap_q,
   output logic             armed_q
);
   localparam logic [WIDTH-1:0] TOP = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= '0;
         wrap_q  <= 1'b0;
         armed_q <= 1'b0;
      end else if (load_en) begin
         count_q <= load_val;
         wrap_q  <= 1'b0;
         armed_q <= 1'b1;
      end else if (accept && armed_q) begin
         if (count_down) begin
            count_q <= count_q - 1'b1;
            if (count_q == '0) wrap_q <= 1'b1;
         end else begin
            count_q <= count_q + 1'b1;
            if (count_q == TOP) wrap_q <= 1'b1;
         end
      end
   end

   assert_step_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && armed_q && !count_down && !load_en)
         |=> count_q == WIDTH'($past(count_q) + 1'b1));
   assert_step_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && armed_q && count_down && !load_en)
         |=> count_q == WIDTH'($past(count_q) - 1'b1));
   assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!accept && !load_en) |=> $stable(count_q));
   assert_wrap_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap_q && !load_en) |=> wrap_q);
   assert_locked_until_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed_q && !load_en) |=> ($stable(count_q) && !wrap_q));

endmodule

// File: rtl/evcap_image.sv
module evcap_image #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] count_i,
   input  logic             freeze_req,
   output logic [WIDTH-1:0] image_q,
   output logic             freeze_ack
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         image_q    <= '0;
         freeze_ack <= 1'b0;
      end else begin
         freeze_ack <= freeze_req;
         if (!freeze_req) image_q <= count_i;
      end
   end

   assert_frozen_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
      freeze_req |=> $stable(image_q));
   assert_ack_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
      freeze_req |=> freeze_ack);
   assert_ack_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !freeze_req |=> !freeze_ack);
   assert_tracks_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !freeze_req |=> image_q == $past(count_i));
   assert_release_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (freeze_ack && !freeze_req) |=> image_q == $past(count_i));

endmodule

// File: rtl/evcap_counter.sv
module evcap_counter #(
   parameter int WIDTH       = 8,
   parameter int SYNC_STAGES = 2,
   parameter int TICK_DIV    = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pin_in,
   input  logic             cell_in,
   input  logic             src_sel,
   input  logic             pin_fall_sel,
   input  logic             count_down,
   input  logic             load_en,
   input  logic [WIDTH-1:0] load_val,
   input  logic             freeze_req,
   output logic             freeze_ack,
   output logic [WIDTH-1:0] image_q,
   output logic             wrap_flag
);
   import evcap_pkg::*;

   localparam int GAP = spacing_gap(TICK_DIV);

   initial begin
      assert (WIDTH >= 2 && WIDTH <= 32) else $error("WIDTH out of range");
      assert (SYNC_STAGES >= 0 && SYNC_STAGES <= 4) else $error("SYNC_STAGES out of range");
      assert (TICK_DIV >= 1) else $error("TICK_DIV must be positive");
   end

   logic             ev_raw;
   logic             accept;
   logic             armed;
   logic [WIDTH-1:0] count;

   evcap_edge_sel #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .cell_in(cell_in),
      .src_sel(src_sel), .pin_fall_sel(pin_fall_sel), .ev_raw(ev_raw));

   evcap_spacer #(.GAP(GAP)) u_space (
      .clk(clk), .rst_n(rst_n), .ev_raw(ev_raw),
      .enable(armed && !load_en), .clear(load_en), .accept(accept));

   evcap_core #(.WIDTH(WIDTH)) u_core (
      .clk(clk), .rst_n(rst_n), .accept(accept), .count_down(count_down),
      .load_en(load_en), .load_val(load_val), .count_q(count),
      .wrap_q(wrap_flag), .armed_q(armed));

   evcap_image #(.WIDTH(WIDTH)) u_image (
      .clk(clk), .rst_n(rst_n), .count_i(count), .freeze_req(freeze_req),
      .image_q(image_q), .freeze_ack(freeze_ack));

   // counting continues while the snapshot is held (R7)
   assert_count_while_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (freeze_ack && accept && !load_en) |=> (count != $past(count)));

endmodule

// File: tb/evcap_counter_bench.sv
module evcap_counter_bench;
   localparam int W    = 8;
   localparam int MAXV = (1 << W) - 1;
   localparam int GAP  = 4 + 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pin_in = 1'b0, cell_in = 1'b0, src_sel = 1'b0, pin_fall_sel = 1'b0;
   logic count_down = 1'b0, load_en = 1'b0, freeze_req = 1'b0;
   logic [W-1:0] load_val = '0;
   logic freeze_ack, wrap_flag;
   logic [W-1:0] image_q;

   always #4 clk = ~clk;

   evcap_counter #(.WIDTH(W), .SYNC_STAGES(2), .TICK_DIV(4)) u_evcap_counter (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .cell_in(cell_in),
      .src_sel(src_sel), .pin_fall_sel(pin_fall_sel), .count_down(count_down),
      .load_en(load_en), .load_val(load_val), .freeze_req(freeze_req),
      .freeze_ack(freeze_ack), .image_q(image_q), .wrap_flag(wrap_flag));

   int n_chk = 0, n_fail = 0;
   int t = 0;
   int last_acc = -1000;
   int exp_cnt = 0;
   bit exp_wrap = 1'b0;
   bit armed_m = 1'b0;
   bit done = 1'b0;

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, t);
      end
   endtask

   function automatic int next_val(input int c, input bit down);
      if (down) return (c == 0) ? MAXV : c - 1;
      return (c == MAXV) ? 0 : c + 1;
   endfunction

   function automatic bit wraps(input int c, input bit down);
      return down ? (c == 0) : (c == MAXV);
   endfunction

   task automatic adv();
      @(posedge clk);
      t++;
      @(negedge clk);
   endtask

   task automatic model_event(input int ev_t);
      if (armed_m && (ev_t - last_acc >= GAP)) begin
         if (wraps(exp_cnt, count_down)) exp_wrap = 1'b1;
         exp_cnt  = next_val(exp_cnt, count_down);
         last_acc = ev_t;
      end
   endtask

   task automatic cell_pulse(input int d);
      int ev_t;
      cell_in = 1'b1;
      adv();
      ev_t = t;
      cell_in = 1'b0;
      if (src_sel) model_event(ev_t);
      for (int i = 1; i < d; i++) adv();
   endtask

   task automatic pin_set(input logic v);
      bit counts;
      counts = !src_sel && (v != pin_in) && (v == !pin_fall_sel);
      pin_in = v;
      if (counts) model_event(t + 3);
      for (int i = 0; i < 12; i++) adv();
   endtask

   task automatic do_load(input int v);
      load_val = W'(v);
      load_en  = 1'b1;
      adv();
      load_en  = 1'b0;
      exp_cnt  = v;
      exp_wrap = 1'b0;
      armed_m  = 1'b1;
      last_acc = -1000;
      adv();
   endtask

   initial begin
      int seed;
      int pre;
      seed = $urandom(32'd2024);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      adv();
      // reset state
      check("R5 reset image", int'(image_q), 0);
      check("R7 reset ack", int'(freeze_ack), 0);
      check("R4 reset wrap", int'(wrap_flag), 0);

      // no counting before first load
      src_sel = 1'b1;
      cell_pulse(8);
      cell_pulse(8);
      check("R5 locked before load", int'(image_q), 0);

      do_load(10);
      check("R5 load value", int'(image_q), 10);

      // snapshot lags count by one cycle
      cell_in = 1'b1;
      adv();
      cell_in = 1'b0;
      check("R6 image before update", int'(image_q), 10);
      adv();
      check("R6 image after update", int'(image_q), 11);
      exp_cnt = 11;
      last_acc = t - 1;
      for (int i = 0; i < 8; i++) adv();

      // pin polarity
      src_sel = 1'b0;
      pin_fall_sel = 1'b0;
      pin_set(1'b1);
      check("R1 rising edge counts", int'(image_q), 12);
      pin_set(1'b0);
      check("R1 falling edge ignored", int'(image_q), 12);
      pin_fall_sel = 1'b1;
      pin_set(1'b1);
      check("R1 rising ignored in falling mode", int'(image_q), 12);
      pin_set(1'b0);
      check("R1 falling edge counts", int'(image_q), 13);

      // source select
      cell_pulse(8);
      check("R2 cell ignored when pin selected", int'(image_q), 13);
      src_sel = 1'b1;
      pin_set(1'b1);
      pin_set(1'b0);
      check("R2 pin ignored when cell selected", int'(image_q), 13);
      cell_in = 1'b1;
      adv();
      model_event(t);
      for (int i = 0; i < 5; i++) adv();
      cell_in = 1'b0;
      for (int i = 0; i < 8; i++) adv();
      check("R2 held level counts once", int'(image_q), 14);

      // down counting
      count_down = 1'b1;
      for (int i = 0; i < 3; i++) cell_pulse(8);
      check("R3 count down", int'(image_q), 11);
      count_down = 1'b0;

      // spacing: too close drops, exact gap accepted
      cell_pulse(GAP - 1);
      cell_pulse(GAP - 1);
      cell_pulse(GAP + 2);
      check("R9 early event dropped", int'(image_q), 13);
      check("R9 model agrees", int'(image_q), exp_cnt);
      for (int i = 0; i < 3; i++) cell_pulse(GAP);
      cell_pulse(8);
      check("R9 exact gap accepted", int'(image_q), 17);

      // wrap up and down
      do_load(MAXV - 1);
      for (int i = 0; i < 3; i++) cell_pulse(8);
      check("R4 wrap up value", int'(image_q), 1);
      check("R4 wrap flag set", int'(wrap_flag), 1);
      for (int i = 0; i < 10; i++) adv();
      check("R4 wrap flag sticky", int'(wrap_flag), 1);
      do_load(1);
      check("R5 load clears wrap", int'(wrap_flag), 0);
      count_down = 1'b1;
      for (int i = 0; i < 3; i++) cell_pulse(8);
      check("R4 wrap down value", int'(image_q), MAXV - 1);
      check("R4 wrap flag on underflow", int'(wrap_flag), 1);
      count_down = 1'b0;

      // freeze handshake
      do_load(50);
      freeze_req = 1'b1;
      adv();
      check("R7 ack after one clock", int'(freeze_ack), 1);
      check("R7 image at freeze", int'(image_q), 50);
      for (int i = 0; i < 3; i++) cell_pulse(8);
      check("R7 image held while counting", int'(image_q), 50);
      check("R7 ack held", int'(freeze_ack), 1);
      freeze_req = 1'b0;
      adv();
      check("R8 reload on release", int'(image_q), 53);
      check("R7 ack drops", int'(freeze_ack), 0);

      // seeded random pulse train
      for (int k = 0; k < 400; k++) begin
         if ($urandom_range(39, 0) == 0) do_load(int'($urandom_range(MAXV, 0)));
         if ($urandom_range(3, 0) == 0) count_down = ~count_down;
         pre = int'($urandom_range(9, 2));
         cell_pulse(pre);
         if (k % 20 == 19) begin
            adv();
            check("R3 R9 random count", int'(image_q), exp_cnt);
            check("R4 random wrap flag", int'(wrap_flag), int'(exp_wrap));
         end
      end
      adv();
      check("R3 random final count", int'(image_q), exp_cnt);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule